// File: doc/BRIEF.md
# Text Cursor Match and Blink Control

This block decides, character by character, whether the text cursor is drawn. A character-based display controller presents the linear refresh memory address of the character being fetched, together with the scan-line (row) address inside the current character row. The block compares that address with a 14-bit cursor position, split into a 6-bit upper part and an 8-bit lower part. It also checks that the row address lies inside a programmable window of scan lines, from a start line through an end line.

A 2-bit mode field selects one of four behaviours: a steady cursor, no cursor, or a cursor that blinks at 1/16 or 1/32 of the field rate. Blink timing comes from a 5-bit field counter that advances on each one-cycle field strobe from the vertical timing logic. The row address input is whatever the row counter upstream produces. In interlaced video operation that is the stepped even or odd sequence, and the window compare uses it as given.

The decision is registered, so the cursor flag appears one clock after the address it belongs to. This keeps it in step with the registered character address at the memory side. The flag is held low whenever display enable is inactive.

Top module: `txt_cursor_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, cur_vis is low after that edge and the field counter returns to 0.
- R2: cur_vis can only be high when the sampled char_addr equals {pos_hi, pos_lo}, with pos_hi forming bits 13:8 and pos_lo forming bits 7:0.
- R3: cur_vis can only be high when the sampled scan_line satisfies line_first <= scan_line <= line_last; if line_first > line_last the cursor never shows.
- R4: Mode 2'b00 shows a steady cursor whenever R2, R3 and R8 allow it.
- R5: Mode 2'b01 keeps cur_vis low for every address and line.
- R6: Mode 2'b10 shows the cursor only while bit 3 of the field counter is 1; the counter starts at 0 and adds one on each clock where fld_stb is high.
- R7: Mode 2'b11 shows the cursor only while bit 4 of the field counter is 1.
- R8: When disp_en is low at a clock edge, cur_vis is low after that edge.
- R9: cur_vis is registered: it reflects the inputs sampled at the previous rising edge and does not change between edges.
- R10: The field counter wraps from 31 to 0, so after 32 strobes both blink modes hide the cursor again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fld_stb | input | 1 | One-cycle strobe per vertical field |
| disp_en | input | 1 | Display enable for the current character |
| char_addr | input | 14 | Linear refresh memory address of the current character |
| scan_line | input | 5 | Row address within the character row |
| pos_hi | input | 6 | Cursor position, upper 6 bits |
| pos_lo | input | 8 | Cursor position, lower 8 bits |
| line_first | input | 5 | First scan line of the cursor |
| line_last | input | 5 | Last scan line of the cursor |
| cur_mode | input | 2 | Cursor mode: 00 steady, 01 off, 10 blink /16, 11 blink /32 |
| cur_vis | output | 1 | Cursor flag, one cycle after its address |

## Verification
The cursor flag is due exactly one rising edge after the address, line, mode and enable that produce it. The bench therefore drives every input on a falling edge and reads cur_vis five nanoseconds after the following rising edge. One directed case reads the flag before that edge as well, to show it still holds the previous value. A field strobe updates the counter at the edge where it is seen, and the flag uses the new count one edge later. The blink checks allow for that extra edge before sampling.

// File: rtl/txt_cursor_pkg.sv
// Shared types for the text cursor block.
// Assumes: mode encoding is fixed by the register layout upstream.
package txt_cursor_pkg;

    // Cursor display mode, as held in the 2-bit mode field
    typedef enum logic [1:0] {
        CUR_STEADY  = 2'b00,
        CUR_OFF     = 2'b01,
        CUR_BLINK16 = 2'b10,
        CUR_BLINK32 = 2'b11
    } cur_mode_e;

endpackage

// File: rtl/cur_addr_match.sv
// Compares the character address with the cursor position formed from
// an upper and a lower register part.
// Assumes: HI_W < ADDR_W; the upper part supplies the most significant bits.
module cur_addr_match #(
    parameter int ADDR_W = 14,
    parameter int HI_W   = 6
) (
    input  logic [ADDR_W-1:0]      char_addr,
    input  logic [HI_W-1:0]        pos_hi,
    input  logic [ADDR_W-HI_W-1:0] pos_lo,
    output logic                   hit
);
    localparam int LO_W = ADDR_W - HI_W;

    logic [ADDR_W-1:0] pos_full;

    // Join the two parts and compare with the current address
    always_comb begin
        pos_full = {pos_hi, pos_lo[LO_W-1:0]};
        hit      = (char_addr == pos_full);
    end
endmodule

// File: rtl/cur_line_window.sv
// Checks that the scan line lies inside the inclusive cursor line window.
// Assumes: an inverted window (first > last) shows nothing.
module cur_line_window #(
    parameter int ROW_W = 5
) (
    input  logic [ROW_W-1:0] scan_line,
    input  logic [ROW_W-1:0] line_first,
    input  logic [ROW_W-1:0] line_last,
    output logic             in_win
);
    // Inclusive range test on both bounds
    always_comb begin
        in_win = (scan_line >= line_first) && (scan_line <= line_last);
    end
endmodule

// File: rtl/cur_blink_gen.sv
// Field counter and mode decode giving the cursor on/off phase.
// Assumes: fld_stb is one cycle wide per field; synchronous active-low reset.
module cur_blink_gen
    import txt_cursor_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int FAST_BIT = 3,
    parameter int SLOW_BIT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fld_stb,
    input  logic [1:0] mode,
    output logic       phase_on
);
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] fld_cnt;
    cur_mode_e        mode_e;

    // Advance the field counter once per field strobe, wrapping naturally
    always_ff @(posedge clk) begin
        if (!rst_n)
            fld_cnt <= '0;
        else if (fld_stb)
            fld_cnt <= fld_cnt + CNT_ONE;
    end

    // Pick the visible phase for the selected mode
    always_comb begin
        mode_e = cur_mode_e'(mode);
        case (mode_e)
            CUR_STEADY:  phase_on = 1'b1;
            CUR_OFF:     phase_on = 1'b0;
            CUR_BLINK16: phase_on = fld_cnt[FAST_BIT];
            default:     phase_on = fld_cnt[SLOW_BIT];
        endcase
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_stb |=> (fld_cnt == $past(fld_cnt) + CNT_ONE));

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fld_stb |=> $stable(fld_cnt));

    // R1
    cnt_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (fld_cnt == '0));
endmodule

// File: rtl/txt_cursor_ctl.sv
// Top of the text cursor block: combines address match, line window,
// blink phase and display enable, and registers the cursor flag so it
// lines up with the registered character address.
// Assumes: inputs are synchronous to clk; reset is synchronous, active low.
module txt_cursor_ctl
    import txt_cursor_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int HI_W   = 6,
    parameter int ROW_W  = 5,
    parameter int CNT_W  = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   fld_stb,
    input  logic                   disp_en,
    input  logic [ADDR_W-1:0]      char_addr,
    input  logic [ROW_W-1:0]       scan_line,
    input  logic [HI_W-1:0]        pos_hi,
    input  logic [ADDR_W-HI_W-1:0] pos_lo,
    input  logic [ROW_W-1:0]       line_first,
    input  logic [ROW_W-1:0]       line_last,
    input  logic [1:0]             cur_mode,
    output logic                   cur_vis
);
    localparam int FAST_BIT = CNT_W - 2;
    localparam int SLOW_BIT = CNT_W - 1;

    logic addr_hit;
    logic line_ok;
    logic phase_on;
    logic vis_next;

    cur_addr_match #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_match (
        .char_addr (char_addr),
        .pos_hi    (pos_hi),
        .pos_lo    (pos_lo),
        .hit       (addr_hit)
    );

    cur_line_window #(.ROW_W(ROW_W)) u_win (
        .scan_line  (scan_line),
        .line_first (line_first),
        .line_last  (line_last),
        .in_win     (line_ok)
    );

    cur_blink_gen #(.CNT_W(CNT_W), .FAST_BIT(FAST_BIT), .SLOW_BIT(SLOW_BIT)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .fld_stb  (fld_stb),
        .mode     (cur_mode),
        .phase_on (phase_on)
    );

    // Combine all conditions for this character
    always_comb begin
        vis_next = disp_en && addr_hit && line_ok && phase_on;
    end

    // Register the flag to match the character address timing
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_vis <= 1'b0;
        else
            cur_vis <= vis_next;
    end

    // R8
    de_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |=> !cur_vis);

    // R5
    mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode == CUR_OFF) |=> !cur_vis);

    // R2
    addr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_vis |-> ($past(char_addr) == {$past(pos_hi), $past(pos_lo)}));

    // R3
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_vis |-> (($past(scan_line) >= $past(line_first)) &&
                     ($past(scan_line) <= $past(line_last))));

    // R1
    vis_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !cur_vis);
endmodule

// File: tb/txt_cursor_ctl_test.sv
module txt_cursor_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fld_stb = 1'b0;
    logic        disp_en = 1'b0;
    logic [13:0] char_addr = '0;
    logic [4:0]  scan_line = '0;
    logic [5:0]  pos_hi = '0;
    logic [7:0]  pos_lo = '0;
    logic [4:0]  line_first = '0;
    logic [4:0]  line_last = '0;
    logic [1:0]  cur_mode = 2'b00;
    logic        cur_vis;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    txt_cursor_ctl uut (
        .clk(clk), .rst_n(rst_n), .fld_stb(fld_stb), .disp_en(disp_en),
        .char_addr(char_addr), .scan_line(scan_line), .pos_hi(pos_hi),
        .pos_lo(pos_lo), .line_first(line_first), .line_last(line_last),
        .cur_mode(cur_mode), .cur_vis(cur_vis)
    );

    typedef struct packed {
        logic [13:0] addr;
        logic [4:0]  line;
        logic [5:0]  hi;
        logic [7:0]  lo;
        logic [4:0]  first;
        logic [4:0]  last;
        logic [1:0]  mode;
        logic        de;
        logic        exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{14'h2A35, 5'd3,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b1, 1'b1}, // R4 hit mid window
        '{14'h2A35, 5'd2,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b1, 1'b1}, // R3 first line
        '{14'h2A35, 5'd5,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b1, 1'b1}, // R3 last line
        '{14'h2A35, 5'd6,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b1, 1'b0}, // R3 below window
        '{14'h2A35, 5'd1,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b1, 1'b0}, // R3 above window
        '{14'h2A36, 5'd3,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b1, 1'b0}, // R2 low part differs
        '{14'h2B35, 5'd3,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b1, 1'b0}, // R2 high part differs
        '{14'h3FFF, 5'd31, 6'h3F, 8'hFF, 5'd31, 5'd31, 2'b00, 1'b1, 1'b1}, // R2 top address
        '{14'h2A35, 5'd3,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b01, 1'b1, 1'b0}, // R5 off
        '{14'h2A35, 5'd3,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b00, 1'b0, 1'b0}, // R8 blanked
        '{14'h2A35, 5'd4,  6'h2A, 8'h35, 5'd6,  5'd2,  2'b00, 1'b1, 1'b0}, // R3 inverted window
        '{14'h2A35, 5'd3,  6'h2A, 8'h35, 5'd2,  5'd5,  2'b10, 1'b1, 1'b0}  // R6 count 0 hidden
    };

    task automatic apply(input vec_t v);
        @(negedge clk);
        char_addr = v.addr; scan_line = v.line; pos_hi = v.hi; pos_lo = v.lo;
        line_first = v.first; line_last = v.last; cur_mode = v.mode; disp_en = v.de;
    endtask

    task automatic check(input string req, input logic exp);
        checks++;
        if (cur_vis !== exp) begin
            errors++;
            $display("FAIL %s cur_vis=%b expected=%b", req, cur_vis, exp);
        end
    endtask

    task automatic settle_check(input string req, input logic exp);
        @(posedge clk); #5;
        check(req, exp);
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fld_stb = 1'b1;
            @(negedge clk); fld_stb = 1'b0;
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk); cur_mode = m;
    endtask

    localparam vec_t HIT = '{14'h0123, 5'd4, 6'h01, 8'h23, 5'd4, 5'd7, 2'b00, 1'b1, 1'b1};

    initial begin
        // R1: reset state with matching inputs and strobes applied
        apply(HIT);
        fld_stb = 1'b1;
        repeat (3) @(posedge clk);
        #5 check("R1", 1'b0);
        @(negedge clk); fld_stb = 1'b0; rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(VECS[k]);
            settle_check("R2/R3/R4/R5/R8 table", VECS[k].exp);
        end

        // R9: output holds until the next rising edge
        apply(VECS[5]);
        settle_check("R9", 1'b0);
        apply(HIT);
        #2 check("R9", 1'b0);
        settle_check("R9", 1'b1);

        // R6 and R7: blink phases from the field counter (count 0 after reset)
        set_mode(2'b11);
        settle_check("R7", 1'b0);
        strobes(8);                          // count 8: bit 3 set
        set_mode(2'b10);
        settle_check("R6", 1'b1);
        set_mode(2'b11);
        settle_check("R7", 1'b0);
        strobes(8);                          // count 16: bit 4 set, bit 3 clear
        settle_check("R7", 1'b1);
        set_mode(2'b10);
        settle_check("R6", 1'b0);
        strobes(15);                         // count 31
        settle_check("R6", 1'b1);
        strobes(1);                          // R10 wrap to 0
        settle_check("R10", 1'b0);
        set_mode(2'b11);
        settle_check("R10", 1'b0);
        set_mode(2'b00);
        settle_check("R4", 1'b1);

        // R1: reset mid-run clears the counter
        strobes(8);
        set_mode(2'b10);
        settle_check("R6", 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        settle_check("R1", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule